// File: doc/BRIEF.md
# Page-buffered nonvolatile write sequencer

This block is the device-side write engine of a byte-wide, page-organised nonvolatile memory model. An external command decoder presents qualified byte-load strobes, each carrying an address and a data byte. The engine gathers these bytes in a page buffer. The page load stays open only while each new byte arrives soon enough after the previous one. When the loads stop, the whole page is committed to the storage array in a single timed internal write.

While the internal write is in progress, the engine ignores new loads. Reads then return a status byte instead of array data: an inverted copy of bit 7 of the last byte loaded, and a bit 6 that flips on every read. Software can poll either bit to find the end of the write. All durations are clock-cycle parameters. The array depth is also a parameter. The full 64K x 8 organisation is reached with `ADDR_W = 16`, and the default is kept small.

Top module: `pgw_page_writer`

## Requirements
- R1: The low 7 address bits select the byte within a 128-byte page, and the bits above them select the page. Every array byte reads FFh after reset.
- R2: The first load while idle opens a page load. A later load whose strobe comes at most WIN_CYC cycles after the previous accepted load is added to the buffer. A repeated offset replaces the earlier byte.
- R3: A load that comes more than WIN_CYC cycles after the previous accepted load ends the page load. Busy rises on that same clock edge, and the late byte is discarded.
- R4: If no load arrives, busy rises on the CLOSE_CYC-th clock edge after the edge that took the last accepted load.
- R5: The committed page is the page of the last accepted load. Every loaded offset carries its latest byte, regardless of the page its load named. Every offset not loaded is written as FFh.
- R6: Busy stays high for exactly WRITE_CYC cycles and cannot be cut short. The page is committed as busy falls, and reads from then on return the new contents.
- R7: Loads presented while busy is high change neither the array nor the next page load.
- R8: A read while busy returns the complement of bit 7 of the last accepted byte in bit 7, and zeros in bits 5..0.
- R9: Bit 6 of the busy-time reads is 1 on the first read after each write starts, and it inverts on each further busy-time read.
- R10: Read data is registered. It appears in the cycle after the read strobe. After reset, rdata is 00h and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Qualified byte-load strobe from the command decoder |
| addr | input | ADDR_W | Address for a load or a read |
| wdata | input | 8 | Byte to load |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data or busy status |
| busy | output | 1 | Internal write in progress |

## Verification
Several load patterns are applied, and each one separates a different fault:
- A full sequential page loaded back to back checks that every offset maps to its own slot.
- A sparse page with repeated offsets exposes a missing FFh fill or an overwrite that keeps the old byte.
- Loads that switch page part-way show whether the commit follows the last page or the first.
- Gaps of exactly WIN_CYC and WIN_CYC+1 cycles bracket the acceptance window.
- Seeded random batches of loads, with random offsets, data and gaps, are compared against a byte model.
- Status reads taken during the write, and loads aimed at a fresh page while busy, separate a correct busy mux from one that leaks array data or accepts writes.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_BUSY = 2'd2
  } pgw_state_e;

  // Byte returned by a read during the internal write
  function automatic logic [7:0] busy_status(input logic last_b7, input logic tog);
    return {~last_b7, tog, 6'b00_0000};
  endfunction

  // A load is taken into the open page when its gap is within the window
  function automatic logic gap_in_window(input int unsigned gap, input int unsigned win);
    return gap <= win;
  endfunction

endpackage

// File: rtl/pgw_cycle_ctr.sv
module pgw_cycle_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         adv,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= W'(1);
    else if (adv)     count <= count + W'(1);
  end
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int OFS_W = 7,
  localparam int PAGE_BYTES = 1 << OFS_W,
  localparam int PAGE_BITS = 8 * PAGE_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 fresh,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [7:0]           data,
  output logic [PAGE_BITS-1:0] page_data
);
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic       used_q;
    logic [7:0] byte_q;
    logic       hit;
    assign hit = take && (ofs == OFS_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q <= 1'b0;
        byte_q <= 8'hFF;
      end else if (hit) begin
        used_q <= 1'b1;
        byte_q <= data;
      end else if (fresh) begin
        used_q <= 1'b0;
      end
    end
    assign page_data[i*8 +: 8] = used_q ? byte_q : 8'hFF;
  end
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int ADDR_W = 11,
  parameter int OFS_W = 7,
  localparam int PG_W = ADDR_W - OFS_W,
  localparam int NUM_PAGES = 1 << PG_W,
  localparam int PAGE_BITS = 8 << OFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [PG_W-1:0]      commit_page,
  input  logic [PAGE_BITS-1:0] commit_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [7:0]           rd_byte
);
  logic [PAGE_BITS-1:0] mem [NUM_PAGES];
  logic [PAGE_BITS-1:0] rd_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAGES; p++) mem[p] <= '1;
    end else if (commit) begin
      mem[commit_page] <= commit_data;
    end
  end

  assign rd_page = mem[rd_addr[ADDR_W-1:OFS_W]];
  assign rd_byte = rd_page[{rd_addr[OFS_W-1:0], 3'b000} +: 8];
endmodule

// File: rtl/pgw_page_writer.sv
module pgw_page_writer
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int OFS_W = 7,
  parameter int WIN_CYC = 5000,
  parameter int CLOSE_CYC = 10000,
  parameter int WRITE_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int PG_W = ADDR_W - OFS_W;
  localparam int PAGE_BITS = 8 << OFS_W;
  localparam int GAP_W = $clog2(CLOSE_CYC + 1);
  localparam int WR_W = $clog2(WRITE_CYC + 1);

  pgw_state_e state_q;
  logic [GAP_W-1:0] gap_cnt;
  logic [WR_W-1:0] wr_cnt;
  logic [PG_W-1:0] last_page_q;
  logic last_d7_q;
  logic tog_q;
  logic [PAGE_BITS-1:0] page_data;
  logic [7:0] arr_byte;

  // Named internal events
  logic load_first, load_accept, load_late, load_take;
  logic gap_expire, close_evt, commit_evt;

  assign load_first  = ld_en && (state_q == ST_IDLE);
  assign load_accept = ld_en && (state_q == ST_LOAD) &&
                       gap_in_window(32'(gap_cnt), WIN_CYC);
  assign load_late   = ld_en && (state_q == ST_LOAD) &&
                       !gap_in_window(32'(gap_cnt), WIN_CYC);
  assign load_take   = load_first || load_accept;
  assign gap_expire  = !ld_en && (state_q == ST_LOAD) && (gap_cnt == GAP_W'(CLOSE_CYC));
  assign close_evt   = load_late || gap_expire;
  assign commit_evt  = (state_q == ST_BUSY) && (wr_cnt == WR_W'(WRITE_CYC));
  assign busy        = (state_q == ST_BUSY);

  pgw_cycle_ctr #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .restart(load_take),
    .adv(state_q == ST_LOAD), .count(gap_cnt)
  );

  pgw_cycle_ctr #(.W(WR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .restart(close_evt),
    .adv(busy), .count(wr_cnt)
  );

  pgw_page_buf #(.OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .take(load_take), .fresh(load_first),
    .ofs(addr[OFS_W-1:0]), .data(wdata), .page_data(page_data)
  );

  pgw_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit_evt), .commit_page(last_page_q),
    .commit_data(page_data), .rd_addr(addr), .rd_byte(arr_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_first) state_q <= ST_LOAD;
        ST_LOAD: if (close_evt)  state_q <= ST_BUSY;
        ST_BUSY: if (commit_evt) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_page_q <= '0;
      last_d7_q   <= 1'b0;
    end else if (load_take) begin
      last_page_q <= addr[ADDR_W-1:OFS_W];
      last_d7_q   <= wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tog_q <= 1'b1;
    else if (close_evt)      tog_q <= 1'b1;
    else if (rd_en && busy)  tog_q <= ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= busy ? busy_status(last_d7_q, tog_q) : arr_byte;
  end
endmodule

// File: rtl/pgw_page_writer_chk.sv
module pgw_page_writer_chk #(
  parameter int WRITE_CYC = 250000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       close_evt,
  input logic       commit_evt,
  input logic       load_take,
  input logic       last_d7_q,
  input logic       tog_q
);
  localparam int BW = $clog2(WRITE_CYC + 1);
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + BW'(1);
    else           bcnt <= '0;
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> int'(bcnt) < WRITE_CYC);
  // R6
  commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (int'(bcnt) == WRITE_CYC - 1) && busy);
  // R7
  no_busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_take |-> !busy);
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(close_evt));
  // R8
  busy_d7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rdata[7] == !$past(last_d7_q)) && (rdata[5:0] == 6'd0));
  // R9
  tog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tog_q);
endmodule

bind pgw_page_writer pgw_page_writer_chk #(.WRITE_CYC(WRITE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en), .rdata(rdata),
  .close_evt(close_evt), .commit_evt(commit_evt), .load_take(load_take),
  .last_d7_q(last_d7_q), .tog_q(tog_q)
);

// File: tb/pgw_page_writer_tb.sv
module pgw_page_writer_tb;
  localparam int AW = 11;
  localparam int WIN = 8;
  localparam int CLOSE = 16;
  localparam int WRC = 40;
  localparam int NBYTES = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic busy;

  int total = 0;
  int bad = 0;
  logic [7:0] model [NBYTES];
  logic [7:0] pbuf [128];
  logic pused [128];
  int last_pg;

  always #2.5 clk = ~clk;

  pgw_page_writer #(.ADDR_W(AW), .OFS_W(7), .WIN_CYC(WIN), .CLOSE_CYC(CLOSE),
                    .WRITE_CYC(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .busy(busy));

  function automatic logic [AW-1:0] mk_addr(input int pg, input int ofs);
    return AW'((pg << 7) | (ofs & 127));
  endfunction

  function automatic logic [7:0] exp_status(input logic d7, input logic t);
    return {~d7, t, 6'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input int pg, input int ofs, input logic [7:0] d, input int w);
    repeat (w) @(negedge clk);
    ld_en = 1'b1; addr = mk_addr(pg, ofs); wdata = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Model side: record a load accepted into the open page
  task automatic take(input int pg, input int ofs, input logic [7:0] d, input bit first);
    if (first) for (int i = 0; i < 128; i++) pused[i] = 1'b0;
    pbuf[ofs] = d; pused[ofs] = 1'b1; last_pg = pg;
  endtask

  task automatic model_commit();
    for (int i = 0; i < 128; i++)
      model[(last_pg << 7) | i] = pused[i] ? pbuf[i] : 8'hFF;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!busy && guard < 1000) begin @(negedge clk); guard++; end
    while (busy && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  task automatic verify_page(input string req, input int pg);
    logic [7:0] d;
    for (int i = 0; i < 128; i++) begin
      do_read(mk_addr(pg, i), d);
      chk(req, d, model[(pg << 7) | i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cnt;
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rdata reset", rdata, 8'h00);
    chk("R10 busy reset", busy, 1'b0);
    // R1 erased array after reset
    do_read(mk_addr(2, 77), d);
    chk("R1 erased byte", d, 8'hFF);

    // R2 full sequential page; one gap placed exactly at the window edge
    for (int i = 0; i < 128; i++) begin
      d = 8'(i * 7 + 3);
      do_load(3, i, d, (i == 64) ? WIN - 1 : 0);
      take(3, i, d, i == 0);
    end
    // R4 busy rises on the CLOSE-th edge after the last load
    repeat (CLOSE - 1) @(negedge clk);
    chk("R4 busy not yet", busy, 1'b0);
    @(negedge clk);
    chk("R4 busy rises", busy, 1'b1);
    // R6 busy duration
    cnt = 0;
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R6 busy cycles", cnt, WRC);
    model_commit();
    verify_page("R2 full page", 3);

    // R5 sparse, repeated offset, page switch; R8/R9 status; R7 ignored load
    do_load(6, 5, 8'h11, 0);  take(6, 5, 8'h11, 1);
    do_load(6, 9, 8'h22, 2);  take(6, 9, 8'h22, 0);
    do_load(6, 5, 8'h33, 1);  take(6, 5, 8'h33, 0);
    do_load(9, 40, 8'h4C, 0); take(9, 40, 8'h4C, 0);
    while (!busy) @(negedge clk);
    do_read(mk_addr(9, 40), d);
    chk("R8 status first", d, exp_status(1'b0, 1'b1));
    do_read(mk_addr(9, 40), d);
    chk("R9 toggle second", d[6], 1'b0);
    do_read(mk_addr(9, 41), d);
    chk("R9 toggle third", d[6], 1'b1);
    do_load(12, 1, 8'h5A, 0);
    chk("R7 still busy", busy, 1'b1);
    while (busy) @(negedge clk);
    model_commit();
    repeat (CLOSE + 4) @(negedge clk);
    chk("R7 no write started", busy, 1'b0);
    do_read(mk_addr(12, 1), d);
    chk("R7 ignored byte", d, 8'hFF);
    verify_page("R5 merged page", 9);
    verify_page("R5 untouched page", 6);

    // R3 late load closes the page and is discarded
    do_load(5, 2, 8'hC1, 0); take(5, 2, 8'hC1, 1);
    do_load(5, 3, 8'hC2, 0); take(5, 3, 8'hC2, 0);
    do_load(5, 10, 8'h77, WIN);
    chk("R3 busy on late load", busy, 1'b1);
    do_read(mk_addr(5, 0), d);
    chk("R8 status msb set", d, exp_status(1'b1, 1'b1));
    while (busy) @(negedge clk);
    model_commit();
    verify_page("R3 late byte dropped", 5);

    // R2 R5 seeded random batches
    for (int t = 0; t < 6; t++) begin
      int pg, n;
      pg = int'($urandom % 16);
      n = 1 + int'($urandom % 40);
      for (int k = 0; k < n; k++) begin
        int o, g, p;
        o = int'($urandom % 128);
        g = int'($urandom % WIN);
        p = (t % 2 == 1 && k == n - 1) ? ((pg + 1) % 16) : pg;
        d = 8'($urandom);
        do_load(p, o, d, (k == 0) ? 0 : g);
        take(p, o, d, k == 0);
      end
      wait_done();
      model_commit();
      verify_page("R5 random batch", last_pg);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule